// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer data-processing stage of a processor datapath. It takes a 4-bit operation code, a first operand and an already-formed second operand (shifts and immediate rotation happen upstream), and produces a 32-bit result, a write enable for the destination, and the next negative, zero, carry and overflow condition flags. The sixteen operations are bitwise operations, moves, add and subtract with and without a carry chain, reversed subtract, and four flag-only test and compare operations.

The current flags enter as a 4-bit field holding status word bits 31 to 28. The carry-in for carry-chained operations is status bit 29. A set-flags input decides whether the computed flags or the incoming flags appear on the flag output. Results are registered: an issue strobe loads the output stage, and the outputs hold while it is low.

Top module: `dp_alu_flags`

## Requirements
- R1: Logical codes compute: 0 A AND B, 1 A XOR B, 8 A AND B, 9 A XOR B, 12 A OR B, 13 B, 14 A AND NOT B, 15 NOT B.
- R2: Arithmetic codes compute, modulo 2^32, with c = flags_in[1] (status bit 29): 2 A-B, 3 B-A, 4 A+B, 5 A+B+c, 6 A-B-(1-c), 7 B-A-(1-c), 10 A-B, 11 A+B.
- R3: On arithmetic codes the computed C flag (flags bit 1) is the carry out of bit 31 for add forms (4, 5, 11) and NOT borrow for subtract forms (2, 3, 6, 7, 10).
- R4: On arithmetic codes the computed V flag (flags bit 0) is set exactly when the signed two's complement result overflows 32 bits; on logical codes V keeps flags_in[0] and C takes shift_carry.
- R5: The computed N flag (bit 3) equals result bit 31 and the computed Z flag (bit 2) is set exactly when the 32-bit result is zero.
- R6: res_we is asserted after an issued operation except for codes 8 to 11, which never assert it.
- R7: With set_flags low, flags_out takes flags_in unchanged for that operation.
- R8: Outputs update on the clock edge after issue is high; while issue is low res_we is 0 and res and flags_out hold.
- R9: After reset res is 0, res_we is 0 and flags_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Load the output stage with this cycle's operation |
| op | input | 4 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Pre-formed second operand |
| flags_in | input | 4 | Current status bits 31..28 as N,Z,C,V |
| shift_carry | input | 1 | Carry from the operand shifter, used by logical codes |
| set_flags | input | 1 | Select computed flags for flags_out |
| res | output | 32 | Registered result |
| res_we | output | 1 | Result write enable |
| flags_out | output | 4 | Next N,Z,C,V |

## Verification
The hardest cases to reach are the carry-chained subtracts at the borrow boundary, where A equals B and the incoming carry alone decides whether the result is zero with C set or all ones with C clear, and the signed overflow edges around 0x80000000 and 0x7FFFFFFF. A directed list drives each of these with both carry-in values and both operand orders before a long stretch of random codes, operands and flag inputs, with the incoming V and the shifter carry varied so that a logical code that wrongly touches them shows up.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  function automatic logic op_is_arith(alu_op_e o);
    return (o inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN});
  endfunction

  function automatic logic op_is_flag_only(alu_op_e o);
    return (o inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
  endfunction
endpackage

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [WIDTH-1:0]   y
);
  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_XOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/dp_addsub_unit.sv
module dp_addsub_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  logic               cin,
  output logic [WIDTH-1:0]   sum,
  output logic               cout,
  output logic               ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x_op;
  logic [WIDTH-1:0] y_op;
  logic             c0;
  logic [WIDTH:0]   wide;

  // Every form reduces to x + y + c0; subtraction inverts the subtrahend.
  always_comb begin
    unique case (op)
      OP_SUB, OP_CMP: begin x_op = a; y_op = ~b; c0 = 1'b1; end
      OP_RSB:         begin x_op = b; y_op = ~a; c0 = 1'b1; end
      OP_ADC:         begin x_op = a; y_op = b;  c0 = cin;  end
      OP_SBC:         begin x_op = a; y_op = ~b; c0 = cin;  end
      OP_RSC:         begin x_op = b; y_op = ~a; c0 = cin;  end
      default:        begin x_op = a; y_op = b;  c0 = 1'b0; end
    endcase
  end

  assign wide = {1'b0, x_op} + {1'b0, y_op} + {{WIDTH{1'b0}}, c0};
  assign sum  = wide[MSB:0];
  assign cout = wide[WIDTH];
  assign ovf  = (x_op[MSB] == y_op[MSB]) && (sum[MSB] != x_op[MSB]);
endmodule

// File: rtl/dp_flag_gen.sv
module dp_flag_gen
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               arith,
  input  logic [WIDTH-1:0]   y,
  input  logic               add_cout,
  input  logic               add_ovf,
  input  logic               shift_c,
  input  alu_flags_t         cur,
  output alu_flags_t         nxt
);
  always_comb begin
    nxt.n = y[WIDTH-1];
    nxt.z = (y == '0);
    nxt.c = arith ? add_cout : shift_c;
    nxt.v = arith ? add_ovf  : cur.v;
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int NFLAGS  = 4,
  parameter int C_INDEX = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [3:0]         op,
  input  logic [WIDTH-1:0]   opa,
  input  logic [WIDTH-1:0]   opb,
  input  logic [NFLAGS-1:0]  flags_in,
  input  logic               shift_carry,
  input  logic               set_flags,
  output logic [WIDTH-1:0]   res,
  output logic               res_we,
  output logic [NFLAGS-1:0]  flags_out
);
  alu_op_e          op_e;
  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] arith_y;
  logic             arith_c;
  logic             arith_v;
  logic             is_arith;
  logic [WIDTH-1:0] y_sel;
  alu_flags_t       cur_f;
  alu_flags_t       calc_f;

  logic [WIDTH-1:0]  res_d,   res_q;
  logic              we_d,    we_q;
  logic [NFLAGS-1:0] flags_d, flags_q;

  assign op_e     = alu_op_e'(op);
  assign cur_f    = alu_flags_t'(flags_in);
  assign is_arith = op_is_arith(op_e);

  dp_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op (op_e), .a (opa), .b (opb), .y (logic_y)
  );

  dp_addsub_unit #(.WIDTH(WIDTH)) u_addsub (
    .op (op_e), .a (opa), .b (opb), .cin (flags_in[C_INDEX]),
    .sum (arith_y), .cout (arith_c), .ovf (arith_v)
  );

  assign y_sel = is_arith ? arith_y : logic_y;

  dp_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .arith (is_arith), .y (y_sel), .add_cout (arith_c), .add_ovf (arith_v),
    .shift_c (shift_carry), .cur (cur_f), .nxt (calc_f)
  );

  // Next-state logic with explicit clock enable.
  always_comb begin
    res_d   = res_q;
    flags_d = flags_q;
    we_d    = 1'b0;
    if (issue) begin
      res_d   = y_sel;
      we_d    = !op_is_flag_only(op_e);
      flags_d = set_flags ? NFLAGS'(calc_f) : flags_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      we_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      res_q   <= res_d;
      we_q    <= we_d;
      flags_q <= flags_d;
    end
  end

  assign res       = res_q;
  assign res_we    = we_q;
  assign flags_out = flags_q;
endmodule

// File: rtl/dp_alu_flags_chk.sv
module dp_alu_flags_chk #(
  parameter int WIDTH  = 32,
  parameter int NFLAGS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue,
  input logic [3:0]        op,
  input logic [NFLAGS-1:0] flags_in,
  input logic              set_flags,
  input logic [WIDTH-1:0]  res,
  input logic              res_we,
  input logic [NFLAGS-1:0] flags_out
);
  // R6: flag-only codes never write
  a_r6_no_write_on_test: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue) && $past(op) inside {4'd8, 4'd9, 4'd10, 4'd11}) |-> !res_we);

  // R6: other codes write
  a_r6_write_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue) && !($past(op) inside {4'd8, 4'd9, 4'd10, 4'd11})) |-> res_we);

  // R8: idle cycles hold outputs and drop the write enable
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(issue)) |-> (!res_we && $stable(res) && $stable(flags_out)));

  // R7: flags pass through when not setting
  a_r7_flag_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue) && !$past(set_flags)) |-> (flags_out == $past(flags_in)));

  // R5: N and Z agree with the registered result
  a_r5_nz_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue) && $past(set_flags)) |-> (flags_out[3] == res[WIDTH-1] && flags_out[2] == (res == '0)));
endmodule

bind dp_alu_flags dp_alu_flags_chk #(.WIDTH(WIDTH), .NFLAGS(NFLAGS)) u_chk (
  .clk (clk), .rst_n (rst_n), .issue (issue), .op (op), .flags_in (flags_in),
  .set_flags (set_flags), .res (res), .res_we (res_we), .flags_out (flags_out)
);

// File: tb/dp_alu_flags_test.sv
module dp_alu_flags_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [3:0]  op;
  logic [31:0] opa, opb;
  logic [3:0]  flags_in;
  logic        shift_carry, set_flags;
  logic [31:0] res;
  logic        res_we;
  logic [3:0]  flags_out;

  int errors = 0;
  int checks = 0;

  logic [31:0] exp_res;
  logic        exp_we;
  logic [3:0]  exp_flags;

  always #2.5 clk = ~clk;

  dp_alu_flags uut (
    .clk (clk), .rst_n (rst_n), .issue (issue), .op (op), .opa (opa), .opb (opb),
    .flags_in (flags_in), .shift_carry (shift_carry), .set_flags (set_flags),
    .res (res), .res_we (res_we), .flags_out (flags_out)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference using 64-bit integer arithmetic.
  task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] fi, input logic sc,
                       output logic [31:0] r, output logic [3:0] f);
    longint ua, ub, sa, sb, t, s, c;
    bit arith, addform;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    c = longint'(fi[1]);
    arith = 1; addform = 0; t = 0; s = 0; r = '0;
    case (o)
      4'd0, 4'd8:  begin arith = 0; r = a & b; end
      4'd1, 4'd9:  begin arith = 0; r = a ^ b; end
      4'd12:       begin arith = 0; r = a | b; end
      4'd13:       begin arith = 0; r = b; end
      4'd14:       begin arith = 0; r = a & ~b; end
      4'd15:       begin arith = 0; r = ~b; end
      4'd2, 4'd10: begin t = ua - ub; s = sa - sb; end
      4'd3:        begin t = ub - ua; s = sb - sa; end
      4'd4, 4'd11: begin t = ua + ub; s = sa + sb; addform = 1; end
      4'd5:        begin t = ua + ub + c; s = sa + sb + c; addform = 1; end
      4'd6:        begin t = ua - ub - (1 - c); s = sa - sb - (1 - c); end
      default:     begin t = ub - ua - (1 - c); s = sb - sa - (1 - c); end
    endcase
    if (arith) begin
      r = t[31:0];
      f[1] = addform ? (t > 64'sh0000_0000_FFFF_FFFF) : (t >= 0);
      f[0] = (s > 64'sh7FFF_FFFF) || (s < -64'sh8000_0000);
    end else begin
      f[1] = sc;
      f[0] = fi[0];
    end
    f[3] = r[31];
    f[2] = (r == 32'd0);
  endtask

  task automatic drive(input logic iss, input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [3:0] fi, input logic sc,
                       input logic sf);
    logic [31:0] r;
    logic [3:0]  f;
    @(negedge clk);
    issue = iss; op = o; opa = a; opb = b; flags_in = fi; shift_carry = sc; set_flags = sf;
    model(o, a, b, fi, sc, r, f);
    if (iss) begin
      exp_res   = r;
      exp_we    = !(o inside {4'd8, 4'd9, 4'd10, 4'd11});
      exp_flags = sf ? f : fi;
    end else begin
      exp_we = 1'b0;
    end
    @(negedge clk);
    // sampled one cycle after the issuing edge
    check((o inside {4'd2,4'd3,4'd4,4'd5,4'd6,4'd7,4'd10,4'd11}) ? "R2 result" : "R1 result",
          64'(res), 64'(exp_res));
    check("R6 R8 res_we", 64'(res_we), 64'(exp_we));
    check("R3 R4 R5 R7 flags", 64'(flags_out), 64'(exp_flags));
    issue = 1'b0;
  endtask

  initial begin : wd
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue = 0; op = 0; opa = 0; opb = 0; flags_in = 0;
    shift_carry = 0; set_flags = 0;
    exp_res = 0; exp_we = 0; exp_flags = 0;
    repeat (3) @(negedge clk);
    check("R9 reset res", 64'(res), 64'd0);
    check("R9 reset res_we", 64'(res_we), 64'd0);
    check("R9 reset flags", 64'(flags_out), 64'd0);
    rst_n = 1'b1;

    // R2 R3 carry-chain boundaries: A==B with both carry-ins
    drive(1, 4'd6, 32'h1234, 32'h1234, 4'b0010, 0, 1); // SBC c=1 -> 0, C=1
    drive(1, 4'd6, 32'h1234, 32'h1234, 4'b0000, 0, 1); // SBC c=0 -> FFFFFFFF, C=0
    drive(1, 4'd7, 32'h5, 32'h5, 4'b0000, 0, 1);       // RSC c=0
    drive(1, 4'd7, 32'h5, 32'h5, 4'b0010, 0, 1);       // RSC c=1
    drive(1, 4'd5, 32'hFFFF_FFFF, 32'h0, 4'b0010, 0, 1); // ADC wraps, C=1, Z=1
    drive(1, 4'd3, 32'h10, 32'h3, 4'b0000, 0, 1);      // RSB borrow
    // R4 signed overflow edges
    drive(1, 4'd4, 32'h7FFF_FFFF, 32'h1, 4'b0000, 0, 1);
    drive(1, 4'd2, 32'h8000_0000, 32'h1, 4'b0000, 0, 1);
    drive(1, 4'd11, 32'h8000_0000, 32'h8000_0000, 4'b0000, 0, 1);
    drive(1, 4'd10, 32'h0, 32'h8000_0000, 4'b0000, 0, 1);
    // R4 logical codes keep V and take shifter carry
    drive(1, 4'd13, 32'h0, 32'h8000_0000, 4'b0001, 1, 1);
    drive(1, 4'd8, 32'hF0, 32'h0F, 4'b0001, 0, 1);
    // R7 flags pass through
    drive(1, 4'd4, 32'hFFFF_FFFF, 32'h1, 4'b1010, 0, 0);
    // R8 idle holds
    drive(0, 4'd15, 32'h1, 32'h2, 4'b0101, 1, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if ((i % 7) == 0) b = a;
      if ((i % 11) == 0) a = 32'h8000_0000;
      if ((i % 13) == 0) b = 32'h7FFF_FFFF;
      drive(($urandom % 5) != 0, 4'($urandom), a, b, 4'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule